// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is an I2C bus master that works one byte at a time under software control through six byte-wide registers. Software writes whole command codes into a control register to open a transfer with a START, to send a repeated START, to close with a STOP, or to turn the bus around into receive. Bytes go out and come in through a single data register, and status flags report each stage of every byte in a fixed order. The engine drives SDA and SCL as open-drain lines: each has a pull-low enable output and a line-level input.

A transfer begins with a START, after which the engine raises a data-empty flag to ask for the address byte. After the eighth bit of every byte the engine raises WAIT and holds SCL low until software clears it. It then clocks the acknowledge bit, flags a missing acknowledge, and raises the data-empty flag. A receive sequence ends when software sets the NACK bit, which makes the engine answer the current byte with NACK and then drive a STOP. BUSY covers the whole span from the first START to the final STOP, including any repeated STARTs. SCL low and high periods come from two count registers, and the high count advances only while the SCL input actually reads high, so a slave can stretch the clock.

Top module: `i2c_byte_master`

## Requirements
- R1: Registers sit at byte offsets 0x00 data, 0x04 control, 0x08 status, 0x0C interrupt enable, 0x10 SCL low count, 0x14 SCL high count. After reset control, enable and all flags read 0, the count registers read their parameter defaults, both lines are released, and status reads {SCL level, SDA level, 0, BUSY, AL, TACK, WAIT, DTE} from bit 7 down to bit 0.
- R2: From idle, a control write with enable (0x80), transmit (0x10) and busy (0x04) set, for example 0x94, produces a START (SDA pulled low while SCL is released). BUSY (status 0x10) is set, then DTE (0x01) is set with SCL held low.
- R3: A data write while the engine holds for the next byte in transmit shifts that byte out MSB first and clears DTE.
- R4: After the eighth bit WAIT (0x02) is set and SCL stays low until software clears WAIT. The acknowledge clock follows. In transmit a high SDA at that clock sets TACK (0x04), and DTE is then set with SCL held low.
- R5: While holding in transmit, a control write of 0x90 (busy bit clear) drives a STOP, after which BUSY clears and both lines are released. A write of 0x94 instead drives a repeated START, with no STOP and with BUSY held at 1.
- R6: While holding, a control write with enable set and transmit clear (0x81) switches to receive and clocks in a byte. The received byte is readable at the data register once WAIT rises.
- R7: In receive the acknowledge clock pulls SDA low while control bit 0x40 is clear. If 0x40 is set (write 0xC0) when the acknowledge clock starts, SDA is released (NACK), a STOP follows, and DTE is set after BUSY clears.
- R8: A status write clears each of flag bits 3..0 that is written 0 and leaves every flag written 1 unchanged.
- R9: The interrupt output is high exactly when some status flag among bits 3..0 is set and its interrupt-enable bit at the same position is set.
- R10: If SDA reads low at the end of an SCL high phase of a transmitted data bit the engine released, AL (0x08) is set, BUSY clears and both lines are released.
- R11: A control write with the enable bit clear returns the engine to idle, releases both lines and clears BUSY. Later data writes start nothing.
- R12: SCL high periods are counted only while the SCL input reads high, so a slave holding SCL low delays the byte and WAIT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Combined interrupt request |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA line level |

## Verification
A behavioural slave on the shared lines logs every byte it sees, answers reads with a counting pattern, and records master acknowledges and STOPs. The bench targets the repeated START: a design that emits a STOP there or drops BUSY would be caught by the STOP counter and the status value. In receive the final byte must get a NACK while the earlier one gets an ACK. Swapping those, or raising DTE before the STOP, shows up in the recorded acknowledge history and the flags. The remaining targets are the single-flag clear in a status write, arbitration loss forced by pulling SDA low under a released 1 bit, and a held SCL that must stall WAIT instead of letting the byte run on a timer.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter logic [7:0] LO_INIT = 8'd20,
  parameter logic [7:0] HI_INIT = 8'd20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [4:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_oe,
  input  logic       scl_in,
  output logic       sda_oe,
  input  logic       sda_in
);

  localparam logic [4:0] A_DATA = 5'h00, A_CTRL = 5'h04, A_STAT = 5'h08,
                         A_IEN  = 5'h0C, A_LO   = 5'h10, A_HI   = 5'h14;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_HOLD, S_BLO, S_BHI, S_WAIT, S_ALO, S_AHI,
    S_PLO, S_PHI, S_PEND, S_RLO, S_RHI
  } st_t;

  st_t        st;
  logic [7:0] ctrl, dreg, ien, lo_cnt, hi_cnt, sh, cnt;
  logic [2:0] bitn;
  logic       busy, al_f, tack_f, wait_f, dte_f, rxm, rx_stop;

  wire wr_data = reg_we && reg_addr == A_DATA;
  wire wr_ctrl = reg_we && reg_addr == A_CTRL;
  wire wr_stat = reg_we && reg_addr == A_STAT;
  wire en_w    = reg_wdata[7];
  wire trs_w   = reg_wdata[4];
  wire bbsy_w  = reg_wdata[2];
  wire lo_done = ({1'b0, cnt} + 9'd1) >= {1'b0, lo_cnt};
  wire hi_done = scl_in && (({1'b0, cnt} + 9'd1) >= {1'b0, hi_cnt});
  wire [3:0] flags = {al_f, tack_f, wait_f, dte_f};

  assign irq = |(flags & ien[3:0]);
  assign scl_oe = (st == S_HOLD) || (st == S_BLO) || (st == S_WAIT) ||
                  (st == S_ALO) || (st == S_PLO) || (st == S_RLO);

  always_comb begin
    case (st)
      S_START, S_PLO, S_PHI: sda_oe = 1'b1;
      S_BLO, S_BHI:          sda_oe = !rxm && !sh[7];
      S_ALO, S_AHI:          sda_oe = rxm && !ctrl[6];
      default:               sda_oe = 1'b0;
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = dreg;
      A_CTRL:  reg_rdata = ctrl;
      A_STAT:  reg_rdata = {scl_in, sda_in, 1'b0, busy, flags};
      A_IEN:   reg_rdata = ien;
      A_LO:    reg_rdata = lo_cnt;
      A_HI:    reg_rdata = hi_cnt;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;   ctrl <= '0;  dreg <= '0;  ien <= '0;
      lo_cnt <= LO_INIT;  hi_cnt <= HI_INIT;
      sh <= '0;  cnt <= '0;  bitn <= '0;
      busy <= 1'b0;  al_f <= 1'b0;  tack_f <= 1'b0;  wait_f <= 1'b0;
      dte_f <= 1'b0;  rxm <= 1'b0;  rx_stop <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= reg_wdata;
      if (reg_we && reg_addr == A_IEN) ien <= reg_wdata;
      if (reg_we && reg_addr == A_LO)  lo_cnt <= reg_wdata;
      if (reg_we && reg_addr == A_HI)  hi_cnt <= reg_wdata;
      if (wr_data) dreg <= reg_wdata;
      if (wr_stat) begin
        al_f   <= al_f   & reg_wdata[3];
        tack_f <= tack_f & reg_wdata[2];
        wait_f <= wait_f & reg_wdata[1];
        dte_f  <= dte_f  & reg_wdata[0];
      end
      cnt <= cnt + 8'd1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (wr_ctrl && en_w && trs_w && bbsy_w) begin
            st <= S_START;  busy <= 1'b1;  rxm <= 1'b0;
          end
        end
        S_START:
          if (hi_done) begin st <= S_HOLD; cnt <= '0; dte_f <= 1'b1; end
          else if (!scl_in) cnt <= cnt;
        S_HOLD: begin
          cnt <= '0;
          if (wr_data) begin
            sh <= reg_wdata;  bitn <= '0;  dte_f <= 1'b0;  st <= S_BLO;
          end else if (wr_ctrl && en_w) begin
            dte_f <= 1'b0;
            if (trs_w && bbsy_w) st <= S_RLO;
            else if (trs_w) begin st <= S_PLO; rx_stop <= 1'b0; end
            else begin rxm <= 1'b1; bitn <= '0; st <= S_BLO; end
          end
        end
        S_BLO:
          if (lo_done) begin st <= S_BHI; cnt <= '0; end
        S_BHI:
          if (hi_done) begin
            cnt <= '0;
            if (!rxm && sh[7] && !sda_in) begin
              al_f <= 1'b1;  busy <= 1'b0;  st <= S_IDLE;
            end else begin
              sh <= {sh[6:0], sda_in};
              if (bitn == 3'd7) begin
                st <= S_WAIT;  wait_f <= 1'b1;
                if (rxm) dreg <= {sh[6:0], sda_in};
              end else begin
                bitn <= bitn + 3'd1;  st <= S_BLO;
              end
            end
          end else if (!scl_in) cnt <= cnt;
        S_WAIT: begin
          cnt <= '0;
          if (!wait_f) st <= S_ALO;
        end
        S_ALO:
          if (lo_done) begin st <= S_AHI; cnt <= '0; end
        S_AHI:
          if (hi_done) begin
            cnt <= '0;
            if (!rxm) begin
              if (sda_in) tack_f <= 1'b1;
              dte_f <= 1'b1;  st <= S_HOLD;
            end else if (ctrl[6]) begin
              rx_stop <= 1'b1;  st <= S_PLO;
            end else begin
              bitn <= '0;  st <= S_BLO;
            end
          end else if (!scl_in) cnt <= cnt;
        S_PLO:
          if (lo_done) begin st <= S_PHI; cnt <= '0; end
        S_PHI:
          if (hi_done) begin st <= S_PEND; cnt <= '0; end
          else if (!scl_in) cnt <= cnt;
        S_PEND:
          if (hi_done) begin
            st <= S_IDLE;  busy <= 1'b0;  rxm <= 1'b0;  rx_stop <= 1'b0;
            if (rx_stop) dte_f <= 1'b1;
          end else if (!scl_in) cnt <= cnt;
        S_RLO:
          if (lo_done) begin st <= S_RHI; cnt <= '0; end
        S_RHI:
          if (hi_done) begin st <= S_START; cnt <= '0; end
          else if (!scl_in) cnt <= cnt;
        default: st <= S_IDLE;
      endcase
      if (wr_ctrl && !en_w) begin
        st <= S_IDLE;  busy <= 1'b0;  rxm <= 1'b0;  rx_stop <= 1'b0;
      end
    end
  end

  AST_START_COND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> sda_oe && !scl_oe);                               // R2
  AST_TX_BIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BHI) && ($past(st) == S_BHI) |-> $stable(sda_oe));        // R3
  AST_WAIT_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    wait_f && busy |-> scl_oe);                                        // R4
  AST_DTE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dte_f) && busy |-> scl_oe);                                  // R4
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !scl_oe && !sda_oe);                               // R5
  AST_AL_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(al_f) |-> !busy && st == S_IDLE);                            // R10

endmodule

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, scl_oe, sda_oe;
  logic       s_scl_hold = 1'b0, s_sda_drv, jam = 1'b0, ack_en = 1'b1;
  int         checks = 0, errors = 0;
  logic       done = 1'b0;

  always #2.5 clk = ~clk;

  wire scl_bus = !scl_oe && !s_scl_hold;
  wire sda_bus = !sda_oe && !s_sda_drv && !jam;

  i2c_byte_master #(.LO_INIT(8'd4), .HI_INIT(8'd4)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_oe(scl_oe), .scl_in(scl_bus), .sda_oe(sda_oe), .sda_in(sda_bus));

  // behavioural slave
  logic       scl_q, sda_q, active, first, rd;
  logic [3:0] bcnt, rx_n;
  logic [7:0] shr, txb, mack_hist;
  logic [7:0] rx_log [0:15];
  int         stop_n;

  always @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1; active <= 1'b0; first <= 1'b0; rd <= 1'b0;
      bcnt <= '0; rx_n <= '0; shr <= '0; txb <= 8'h5A; mack_hist <= '0;
      s_sda_drv <= 1'b0; stop_n <= 0;
    end else begin
      scl_q <= scl_bus; sda_q <= sda_bus;
      if (scl_bus && scl_q && sda_q && !sda_bus) begin
        active <= 1'b1; bcnt <= '0; first <= 1'b1; s_sda_drv <= 1'b0;
      end else if (scl_bus && scl_q && !sda_q && sda_bus) begin
        active <= 1'b0; s_sda_drv <= 1'b0; stop_n <= stop_n + 1;
      end else if (active && scl_bus && !scl_q) begin
        if (bcnt < 4'd8) shr <= {shr[6:0], sda_bus};
        if (bcnt == 4'd8 && rd && !first) mack_hist <= {mack_hist[6:0], !sda_bus};
        bcnt <= bcnt + 4'd1;
      end else if (active && !scl_bus && scl_q) begin
        if (bcnt == 4'd8) begin
          if (first || !rd) begin
            rx_log[rx_n] <= shr; rx_n <= rx_n + 4'd1;
            s_sda_drv <= ack_en;
            if (first) rd <= shr[0];
          end else begin
            s_sda_drv <= 1'b0; txb <= txb + 8'd1;
          end
        end else if (bcnt == 4'd9) begin
          bcnt <= '0; first <= 1'b0;
          if (rd && (first ? ack_en : mack_hist[0])) s_sda_drv <= !txb[7];
          else s_sda_drv <= 1'b0;
        end else if (bcnt >= 4'd1 && rd && !first) begin
          s_sda_drv <= !txb[3'd7 - bcnt[2:0]];
        end
      end
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_flag(input logic [7:0] mask, input string tag);
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd_reg(5'h08, s);
      if ((s & mask) != 0) return;
    end
    check(1'b0, tag, 0, mask);
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd_reg(5'h08, s);
      if (!s[4]) return;
    end
    check(1'b0, tag, 1, 0);
  endtask

  task automatic byte_out(input logic [7:0] b, input string tag);
    wr(5'h00, b);
    wait_flag(8'h02, tag);
    wr(5'h08, 8'hFD);
    wait_flag(8'h01, tag);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd_reg(5'h08, v); check(v == 8'hC0, "R1 status", v, 8'hC0);
    rd_reg(5'h04, v); check(v == 8'h00, "R1 control", v, 0);
    rd_reg(5'h0C, v); check(v == 8'h00, "R1 ienable", v, 0);
    rd_reg(5'h10, v); check(v == 8'h04, "R1 low count", v, 4);
    rd_reg(5'h14, v); check(v == 8'h04, "R1 high count", v, 4);
    check(!irq && !scl_oe && !sda_oe, "R1 outputs idle", {irq, scl_oe, sda_oe}, 0);
  endtask

  task automatic t_write_read;
    logic [7:0] v;
    int sn;
    wr(5'h0C, 8'h01);
    wr(5'h04, 8'h94);
    wait_flag(8'h01, "R2 dte");
    rd_reg(5'h08, v); check((v & 8'h1F) == 8'h11, "R2 busy+dte", v & 8'h1F, 8'h11);
    check(scl_oe == 1'b1, "R2 scl held", scl_oe, 1);
    check(irq == 1'b1, "R9 irq dte", irq, 1);
    wr(5'h00, 8'hA4);
    rd_reg(5'h08, v); check((v & 8'h1F) == 8'h10, "R3 dte cleared", v & 8'h1F, 8'h10);
    wait_flag(8'h02, "R4 wait");
    repeat (40) @(negedge clk);
    rd_reg(5'h08, v); check((v & 8'h1F) == 8'h12, "R4 wait holds", v & 8'h1F, 8'h12);
    check(scl_oe == 1'b1, "R4 scl low in wait", scl_oe, 1);
    check(irq == 1'b0, "R9 wait masked", irq, 0);
    wr(5'h0C, 8'h03);
    check(irq == 1'b1, "R9 wait enabled", irq, 1);
    wr(5'h0C, 8'h01);
    wr(5'h08, 8'hFD);
    wait_flag(8'h01, "R4 dte after ack");
    rd_reg(5'h08, v); check((v & 8'h1F) == 8'h11, "R4 acked no tack", v & 8'h1F, 8'h11);
    check(rx_log[0] == 8'hA4, "R3 address byte", rx_log[0], 8'hA4);
    byte_out(8'h3C, "R3 data");
    check(rx_log[1] == 8'h3C, "R3 data byte", rx_log[1], 8'h3C);
    sn = stop_n;
    wr(5'h04, 8'h94);
    wait_flag(8'h01, "R5 rep start");
    rd_reg(5'h08, v); check((v & 8'h1F) == 8'h11, "R5 busy kept", v & 8'h1F, 8'h11);
    check(stop_n == sn, "R5 no stop", stop_n, sn);
    byte_out(8'hA5, "R5 read addr");
    check(rx_log[2] == 8'hA5, "R5 read addr byte", rx_log[2], 8'hA5);
    wr(5'h04, 8'h81);
    wait_flag(8'h02, "R6 rx wait");
    rd_reg(5'h00, v); check(v == 8'h5A, "R6 rx byte 1", v, 8'h5A);
    wr(5'h08, 8'hFD);
    wait_flag(8'h02, "R6 rx wait 2");
    rd_reg(5'h00, v); check(v == 8'h5B, "R6 rx byte 2", v, 8'h5B);
    wr(5'h04, 8'hC0);
    wr(5'h08, 8'hFD);
    wait_flag(8'h01, "R7 dte after stop");
    rd_reg(5'h08, v); check((v & 8'h1F) == 8'h01, "R7 idle with dte", v & 8'h1F, 8'h01);
    check(stop_n == sn + 1, "R7 stop sent", stop_n, sn + 1);
    check(mack_hist[1:0] == 2'b10, "R7 ack then nack", mack_hist[1:0], 2);
    check(!scl_oe && !sda_oe, "R7 lines released", {scl_oe, sda_oe}, 0);
    wr(5'h08, 8'hFE);
  endtask

  task automatic t_nack_stop;
    logic [7:0] v;
    int sn;
    ack_en = 1'b0;
    wr(5'h0C, 8'h04);
    wr(5'h04, 8'h94);
    wait_flag(8'h01, "R4 start");
    byte_out(8'h20, "R4 nack");
    rd_reg(5'h08, v); check((v & 8'h1F) == 8'h15, "R4 tack set", v & 8'h1F, 8'h15);
    check(irq == 1'b1, "R9 tack irq", irq, 1);
    wr(5'h08, 8'hFB);
    rd_reg(5'h08, v); check((v & 8'h1F) == 8'h11, "R8 only tack cleared", v & 8'h1F, 8'h11);
    check(irq == 1'b0, "R9 irq drops", irq, 0);
    sn = stop_n;
    wr(5'h04, 8'h90);
    wait_idle("R5 stop");
    rd_reg(5'h08, v); check((v & 8'h1F) == 8'h00, "R5 after stop", v & 8'h1F, 0);
    check(stop_n == sn + 1, "R5 stop seen", stop_n, sn + 1);
    check(!scl_oe && !sda_oe, "R5 lines released", {scl_oe, sda_oe}, 0);
    ack_en = 1'b1;
    wr(5'h0C, 8'h00);
  endtask

  task automatic t_arb_lost;
    logic [7:0] v;
    wr(5'h04, 8'h94);
    wait_flag(8'h01, "R10 start");
    jam = 1'b1;
    wr(5'h00, 8'hFF);
    repeat (40) @(negedge clk);
    rd_reg(5'h08, v); check((v & 8'h1F) == 8'h08, "R10 al and idle", v & 8'h1F, 8'h08);
    check(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
    jam = 1'b0;
    wr(5'h0C, 8'h08);
    check(irq == 1'b1, "R9 al irq", irq, 1);
    wr(5'h08, 8'hF7);
    check(irq == 1'b0, "R8 al cleared", irq, 0);
    wr(5'h0C, 8'h00);
  endtask

  task automatic t_disable;
    logic [7:0] v;
    wr(5'h04, 8'h94);
    wait_flag(8'h01, "R11 start");
    wr(5'h04, 8'h00);
    check(!scl_oe && !sda_oe, "R11 lines released", {scl_oe, sda_oe}, 0);
    wr(5'h08, 8'hFE);
    wr(5'h00, 8'h55);
    repeat (60) @(negedge clk);
    rd_reg(5'h08, v); check((v & 8'h1F) == 8'h00, "R11 stays idle", v & 8'h1F, 0);
    check(!scl_oe, "R11 no clocking", scl_oe, 0);
  endtask

  task automatic t_stretch;
    logic [7:0] v;
    wr(5'h04, 8'h94);
    wait_flag(8'h01, "R12 start");
    s_scl_hold = 1'b1;
    wr(5'h00, 8'hA4);
    repeat (200) @(negedge clk);
    rd_reg(5'h08, v); check(v[1] == 1'b0, "R12 stalled by held scl", v[1], 0);
    s_scl_hold = 1'b0;
    wait_flag(8'h02, "R12 wait after release");
    rd_reg(5'h08, v); check(v[1] == 1'b1, "R12 byte completes", v[1], 1);
    wr(5'h08, 8'hFD);
    wait_flag(8'h01, "R12 dte");
    wr(5'h04, 8'h90);
    wait_idle("R12 stop");
    wr(5'h08, 8'hF0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_read();
    t_nack_stop();
    t_arb_lost();
    t_disable();
    t_stretch();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #750000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule